// File: doc/BRIEF.md
# Channel Interrupt Status and Error Capture

This block gathers the interrupt sources of one disk channel and drives a single interrupt request line toward the host. There are two sources: the attached drive's interrupt line and a memory error reported by the channel's bus master engine. Each source has its own pending bit and its own enable bit. The interrupt request is raised while any source is both pending and enabled.

The host reaches the block through a simple 32-bit word register port with separate read and write strobes. Sources are enabled through a set-only register and acknowledged through a write-one-to-clear register, so no read-modify-write sequence is needed. Reading the drive's status byte also acknowledges the channel: when that byte shows the drive is not busy, both pending bits clear. On the first memory error after the error bit was clear, the block latches the failing bus address. That address stays readable as a low word and a high word until the error bit is acknowledged.

A pending set and an acknowledge that arrive in the same cycle resolve in favour of the set, so no event is lost.

Top module: `chan_irq_stat`

## Requirements
- R1: After reset every pending bit, every enable bit and the captured address are zero, and `irq_req` is low.
- R2: A read at word offset 3 returns the pending bits: bit 0 for the drive source, bit 1 for the memory error, and zero in all bits above.
- R3: A 0-to-1 transition on `drv_intrq` sets pending bit 0 at the next clock edge. A line that stays high does not set the bit again after it has been cleared.
- R4: A cycle with `merr_vld` high sets pending bit 1 at the next clock edge.
- R5: A write at word offset 5 sets every enable bit whose data bit is 1 and leaves the others unchanged. A read at offset 5 returns the enable bits in bits 1:0.
- R6: `irq_req` is high exactly when at least one bit is both pending and enabled.
- R7: A write at word offset 7 clears every pending bit whose data bit is 1 and leaves pending bits whose data bit is 0 unchanged.
- R8: A drive status read (`dsr_vld`) whose byte has bit 7 (busy) at 0 clears both pending bits. With bit 7 at 1 it has no effect.
- R9: When a source's set event and a clear (by register write or by status read) reach the same pending bit in the same cycle, the bit ends up set.
- R10: When pending bit 1 goes from 0 to 1, `merr_addr` is captured. A read at word offset 0 returns its low 32 bits and a read at word offset 1 returns its high 32 bits.
- R11: Further memory errors while bit 1 is pending do not change the captured address. After bit 1 is cleared, the next error captures a new address.
- R12: Reads at word offsets 2, 4, 6 and 7 return zero. Writes at offsets 0 to 4 and 6 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd`, zero otherwise |
| drv_intrq | input | 1 | Drive interrupt line, level |
| merr_vld | input | 1 | Memory error event, one cycle per error |
| merr_addr | input | 64 | Failing bus address that comes with `merr_vld` |
| dsr_vld | input | 1 | The host is reading the drive status byte in this cycle |
| dsr_byte | input | 8 | The drive status byte being read |
| irq_req | output | 1 | Interrupt request to the host |

## Verification
On every cycle, the assertions check the following. A pending bit rises only in the cycle after a set event. Every set event leaves its bit pending, even when a clear arrives with it. A clear without a set leaves the bit low. Enable bits never fall. The captured address stays stable while the error bit remains pending. The scenarios in the bench are the only way to show the rest. They sweep every combination of enable mask, pending pattern and clear mask against the computed interrupt level. They also cover the busy-bit gating of status-read clears, an interrupt line held high across a clear, the address word split, and the absence of effect from unused offsets.

// File: rtl/cis_pkg.sv
package cis_pkg;
   // source indices inside the pending and enable vectors
   localparam int SRC_DRV = 0;
   localparam int SRC_MEM = 1;
   // word offsets of the host registers
   localparam int OFF_ADDR_LO = 0;
   localparam int OFF_ADDR_HI = 1;
   localparam int OFF_STAT    = 3;
   localparam int OFF_SET     = 5;
   localparam int OFF_CLR     = 7;
   // busy flag position in the drive status byte
   localparam int DSR_BUSY    = 7;
endpackage

// File: rtl/cis_src_detect.sv
module cis_src_detect #(
   parameter int          NUM_SRC  = 2,
   parameter logic [NUM_SRC-1:0] EDGE_MODE = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   output logic [NUM_SRC-1:0] src_evt
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (EDGE_MODE[i]) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= src_in[i];
         end
         assign src_evt[i] = src_in[i] & ~prev_q;
         AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            src_evt[i] |=> !src_evt[i]);  // R3
      end else begin : g_pulse
         assign src_evt[i] = src_in[i];
      end
   end
endmodule

// File: rtl/cis_pend_bank.sv
module cis_pend_bank #(
   parameter int NUM_SRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_evt,
   input  logic [NUM_SRC-1:0] clr_mask,
   input  logic [NUM_SRC-1:0] en_set,
   output logic [NUM_SRC-1:0] pend_q,
   output logic [NUM_SRC-1:0] en_q,
   output logic               irq
);
   logic [NUM_SRC-1:0] active;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            pend_q[i] <= 1'b0;
         else if (set_evt[i])   pend_q[i] <= 1'b1;
         else if (clr_mask[i])  pend_q[i] <= 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          en_q[i] <= 1'b0;
         else if (en_set[i])  en_q[i] <= 1'b1;
      end
      assign active[i] = pend_q[i] & en_q[i];

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_evt[i] |=> pend_q[i]);  // R9
      AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_mask[i] && !set_evt[i]) |=> !pend_q[i]);  // R7
      AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend_q[i]) |-> $past(set_evt[i]));  // R4
      AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         en_q[i] |=> en_q[i]);  // R5
   end

   assign irq = |active;
endmodule

// File: rtl/cis_err_cap.sv
module cis_err_cap #(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              err_set,
   input  logic              err_pend,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_q
);
   logic take;
   assign take = err_set & ~err_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (take) addr_q <= addr_in;
   end

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (err_pend && $past(err_pend)) |-> $stable(addr_q));  // R11
endmodule

// File: rtl/cis_regif.sv
module cis_regif
   import cis_pkg::*;
#(
   parameter int NUM_SRC = 2,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 64,
   parameter int REG_AW  = 3
) (
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] en,
   input  logic [ADDR_W-1:0] cap_addr,
   output logic [NUM_SRC-1:0] set_mask,
   output logic [NUM_SRC-1:0] clr_mask,
   output logic [DATA_W-1:0] reg_rdata
);
   localparam int EXT_W = 2 * DATA_W;

   logic [EXT_W-1:0]  addr_ext;
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      addr_ext = '0;
      addr_ext[ADDR_W-1:0] = cap_addr;
   end

   assign set_mask = (reg_wr && reg_addr == REG_AW'(OFF_SET)) ? reg_wdata[NUM_SRC-1:0] : '0;
   assign clr_mask = (reg_wr && reg_addr == REG_AW'(OFF_CLR)) ? reg_wdata[NUM_SRC-1:0] : '0;

   always_comb begin
      rd_mux = '0;
      if (reg_addr == REG_AW'(OFF_ADDR_LO))      rd_mux = addr_ext[DATA_W-1:0];
      else if (reg_addr == REG_AW'(OFF_ADDR_HI)) rd_mux = addr_ext[EXT_W-1:DATA_W];
      else if (reg_addr == REG_AW'(OFF_STAT))    rd_mux[NUM_SRC-1:0] = pend;
      else if (reg_addr == REG_AW'(OFF_SET))     rd_mux[NUM_SRC-1:0] = en;
   end

   assign reg_rdata = reg_rd ? rd_mux : '0;

   always_comb begin
      if (!reg_rd) AST_RD_IDLE: assert (reg_rdata == '0);  // R12
   end
endmodule

// File: rtl/chan_irq_stat.sv
module chan_irq_stat
   import cis_pkg::*;
#(
   parameter int NUM_SRC = 2,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 64,
   parameter int REG_AW  = 3,
   parameter int DSR_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              drv_intrq,
   input  logic              merr_vld,
   input  logic [ADDR_W-1:0] merr_addr,
   input  logic              dsr_vld,
   input  logic [DSR_W-1:0]  dsr_byte,
   output logic              irq_req
);
   // drive line is edge sensed, memory error arrives as a pulse
   localparam logic [NUM_SRC-1:0] EDGE_MODE = NUM_SRC'(1) << SRC_DRV;

   if (NUM_SRC != 2)              begin : g_bad_src  $error("NUM_SRC must be 2");            end
   if (ADDR_W <= DATA_W || ADDR_W > 2 * DATA_W)
                                  begin : g_bad_addr $error("ADDR_W must fit two data words"); end
   if (REG_AW < 3)                begin : g_bad_aw   $error("REG_AW must reach offset 7");    end
   if (DSR_W <= DSR_BUSY)         begin : g_bad_dsr  $error("status byte lacks busy bit");    end

   logic [NUM_SRC-1:0] src_in, src_evt, set_mask, wclr_mask, clr_all, pend_q, en_q;
   logic [ADDR_W-1:0]  cap_addr;
   logic               dsr_clr, irq_int;

   always_comb begin
      src_in          = '0;
      src_in[SRC_DRV] = drv_intrq;
      src_in[SRC_MEM] = merr_vld;
   end

   assign dsr_clr = dsr_vld & ~dsr_byte[DSR_BUSY];
   assign clr_all = wclr_mask | {NUM_SRC{dsr_clr}};

   cis_src_detect #(.NUM_SRC(NUM_SRC), .EDGE_MODE(EDGE_MODE)) u_det (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_evt(src_evt));

   cis_pend_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_evt(src_evt), .clr_mask(clr_all),
      .en_set(set_mask), .pend_q(pend_q), .en_q(en_q), .irq(irq_int));

   cis_err_cap #(.ADDR_W(ADDR_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .err_set(src_evt[SRC_MEM]),
      .err_pend(pend_q[SRC_MEM]), .addr_in(merr_addr), .addr_q(cap_addr));

   cis_regif #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_reg (
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .pend(pend_q), .en(en_q), .cap_addr(cap_addr), .set_mask(set_mask),
      .clr_mask(wclr_mask), .reg_rdata(reg_rdata));

   assign irq_req = irq_int;

   AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (dsr_vld && dsr_byte[DSR_BUSY] && !reg_wr && pend_q[SRC_DRV]) |=> pend_q[SRC_DRV]);  // R8
   AST_IDLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (dsr_clr && !(|src_evt)) |=> (pend_q == '0));  // R8
endmodule

// File: tb/sim_chan_irq_stat.sv
module sim_chan_irq_stat;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        drv_intrq = 1'b0, merr_vld = 1'b0, dsr_vld = 1'b0;
   logic [63:0] merr_addr = '0;
   logic [7:0]  dsr_byte = '0;
   logic        irq_req;

   int total = 0, bad = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   chan_irq_stat u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drv_intrq(drv_intrq),
      .merr_vld(merr_vld), .merr_addr(merr_addr), .dsr_vld(dsr_vld),
      .dsr_byte(dsr_byte), .irq_req(irq_req));

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      drv_intrq = 0; merr_vld = 0; dsr_vld = 0; reg_wr = 0; reg_rd = 0;
      rst_n = 0; tick(); tick();
      @(negedge clk); rst_n = 1;
   endtask

   task automatic wr(int off, logic [31:0] d);
      @(negedge clk); reg_wr = 1; reg_addr = 3'(off); reg_wdata = d;
      tick(); reg_wr = 0;
   endtask

   task automatic rd(int off, output logic [31:0] d);
      @(negedge clk); reg_rd = 1; reg_addr = 3'(off);
      #1 d = reg_rdata;
      reg_rd = 0;
   endtask

   task automatic merr(logic [63:0] a);
      @(negedge clk); merr_vld = 1; merr_addr = a;
      tick(); merr_vld = 0;
   endtask

   task automatic drv_pulse();
      @(negedge clk); drv_intrq = 1; tick();
      @(negedge clk); drv_intrq = 0; tick();
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, lo, hi;
      do_reset();
      // R1: reset state
      rd(0, d); chk("R1 addr lo", d, 0);
      rd(1, d); chk("R1 addr hi", d, 0);
      rd(3, d); chk("R1 pending", d, 0);
      rd(5, d); chk("R1 enable", d, 0);
      chk("R1 irq", irq_req, 0);

      // R2 R4 R5 R6 R7 sweep enable x pending x clear mask
      for (int e = 0; e < 4; e++)
         for (int p = 0; p < 4; p++)
            for (int c = 0; c < 4; c++) begin
               do_reset();
               wr(5, 32'(e));
               if (p[1]) merr(64'h0);
               if (p[0]) drv_pulse();
               rd(3, d); chk("R2 status", d, 32'(p));
               rd(5, d); chk("R5 enable", d, 32'(e));
               @(negedge clk); chk("R6 irq", irq_req, 64'(|(p & e)));
               wr(7, 32'(c));
               rd(3, d); chk("R7 clear mask", d, 32'(p & ~c));
               @(negedge clk); chk("R6 irq after clear", irq_req, 64'(|(p & ~c & e)));
            end

      // R5: set register only adds bits
      do_reset();
      wr(5, 1); wr(5, 2); wr(5, 0);
      rd(5, d); chk("R5 set accumulates", d, 3);

      // R3: held-high line sets once
      do_reset();
      @(negedge clk); drv_intrq = 1; tick();
      rd(3, d); chk("R3 edge sets", d, 1);
      wr(7, 1); tick(); tick();
      rd(3, d); chk("R3 held line no reset", d, 0);
      @(negedge clk); drv_intrq = 0; tick();
      @(negedge clk); drv_intrq = 1; tick();
      rd(3, d); chk("R3 new edge", d, 1);
      @(negedge clk); drv_intrq = 0;

      // R8: status read gated by busy bit 7
      do_reset();
      merr(64'h5); drv_pulse();
      @(negedge clk); dsr_vld = 1; dsr_byte = 8'h80; tick(); dsr_vld = 0;
      rd(3, d); chk("R8 busy keeps", d, 3);
      @(negedge clk); dsr_vld = 1; dsr_byte = 8'h50; tick(); dsr_vld = 0;
      rd(3, d); chk("R8 idle clears", d, 0);

      // R9: set and clear in the same cycle
      do_reset();
      @(negedge clk); drv_intrq = 1; reg_wr = 1; reg_addr = 3'd7; reg_wdata = 3;
      tick(); reg_wr = 0;
      rd(3, d); chk("R9 edge vs clear write", d, 1);
      @(negedge clk); drv_intrq = 0;
      @(negedge clk); merr_vld = 1; merr_addr = 64'h77; dsr_vld = 1; dsr_byte = 8'h00;
      tick(); merr_vld = 0; dsr_vld = 0;
      rd(3, d); chk("R9 error vs status read", d, 2);

      // R10 R11: address capture
      do_reset();
      merr(64'h1234_5678_9ABC_DEF0);
      rd(0, lo); rd(1, hi);
      chk("R10 capture", {hi, lo}, 64'h1234_5678_9ABC_DEF0);
      merr(64'hFFFF_0000_FFFF_0000);
      rd(0, lo); rd(1, hi);
      chk("R11 held while pending", {hi, lo}, 64'h1234_5678_9ABC_DEF0);
      wr(7, 2);
      rd(0, lo); rd(1, hi);
      chk("R11 kept after clear", {hi, lo}, 64'h1234_5678_9ABC_DEF0);
      merr(64'h0BAD_F00D_CAFE_0001);
      rd(0, lo); rd(1, hi);
      chk("R11 new capture", {hi, lo}, 64'h0BAD_F00D_CAFE_0001);

      // R12: unused offsets
      do_reset();
      merr(64'hA5A5); wr(5, 1);
      for (int o = 0; o < 7; o++) if (o != 5) wr(o, 32'hFFFF_FFFF);
      rd(3, d); chk("R12 pending untouched", d, 2);
      rd(5, d); chk("R12 enable untouched", d, 1);
      rd(0, d); chk("R12 addr untouched", d, 32'hA5A5);
      rd(2, d); chk("R12 off2", d, 0);
      rd(4, d); chk("R12 off4", d, 0);
      rd(6, d); chk("R12 off6", d, 0);
      rd(7, d); chk("R12 off7", d, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule